// File: doc/BRIEF.md
# Isochronous Resource Manager Lock Registers

This block holds the four registers that a serial-bus node offers to other nodes while it acts as isochronous resource manager. The registers are the bus manager identity, the free isochronous bandwidth, and two 32-bit masks of free channels (an upper and a lower word). Other nodes claim and release these resources with compare-and-swap lock transactions. Each transaction arrives as one request on a single-cycle request strobe. The block answers it one cycle later with a response code and the value defined for that register.

The bandwidth and channel registers do not use a plain swap. A bandwidth lock is read as a request to allocate or free the difference between `arg` and `data`. It only succeeds if the result stays inside the 13-bit range. A channel lock only flips the bits in which `arg` and `data` differ, and only if those bits currently match `arg`. Channel 31 is bit 0 of the upper channel word, and it can never be released. A 64-bit lock treats the two channel words as one value. A synchronous bus-reset input restores all four registers to their power-up values.

The register window uses aligned 32-bit word offsets. The offset order is fixed because a 64-bit lock spans the upper channel word and the word after it.

Top module: `irm_lock_regs`

## Requirements
- R1: After `rst_n` low or a cycle with `bus_reset` high, the registers read bus manager = 0x3F, bandwidth = 4915 (0x1333), channels upper = 0xFFFFFFFE and channels lower = 0xFFFFFFFF. The register offsets are 0x00, 0x04, 0x08 and 0x0C in that order.
- R2: A bus manager lock (kind 2, compare-swap code 2) returns the old value. It stores `data` only when the register equals `arg`.
- R3: A bandwidth lock whose 32-bit `arg` exceeds 0x1FFF changes nothing and returns the current value.
- R4: When `arg` ≥ `data[12:0]`, the amount `arg − data` is allocated. If the register holds at least that amount, the register drops by it and `arg` is returned. Otherwise the register is unchanged and the current value is returned.
- R5: When `arg` < `data[12:0]`, the amount `data − arg` is freed. If register + amount < 0x2000, the amount is added and `arg` is returned. Otherwise the register is unchanged and the current value is returned.
- R6: A channel lock forms `aff = arg ^ data`. When `arg & aff` equals `reg & aff`, the register toggles the bits in `aff` and returns `arg`. Otherwise it is unchanged and the current register value is returned.
- R7: Bit 0 of the upper channel word (channel 31) is forced to 0 in `data` for both 32-bit and 64-bit locks, so that channel stays allocated.
- R8: A 64-bit lock (kind 3) at offset 0x08 applies the R6 rule to {upper, lower}, and returns a 64-bit value with the upper word in bits 63:32.
- R9: A plain write (kind 1) to any of the four registers returns type error (code 1) and changes no register.
- R10: The following return type error (code 1) with value 0:
  - any unaligned address;
  - a lock whose code is not 2 at a mapped offset;
  - a 64-bit lock at a mapped offset other than 0x08.
- R11: Any aligned offset outside the four registers returns address error (code 2) with value 0.
- R12: Each request is answered exactly one cycle later with `rsp_valid`. A read (kind 0) of a mapped register returns complete (code 0) with the value zero-extended. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Synchronous restore of the default register values |
| req_valid | input | 1 | One-cycle request strobe |
| req_kind | input | 2 | 0 read, 1 write, 2 lock 32-bit, 3 lock 64-bit |
| req_addr | input | ADDR_W | Byte offset within the register window |
| req_ext | input | EXT_W | Lock operation code; 2 = compare-swap |
| req_arg | input | 64 | Lock argument; bits 31:0 for 32-bit locks |
| req_data | input | 64 | Lock data; bits 31:0 for 32-bit locks |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_code | output | 2 | 0 complete, 1 type error, 2 address error |
| rsp_value | output | 64 | Returned value |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is low at time zero.
- `bus_reset` never coincides with a request whose effect is being judged.
- `req_valid` carries fully known fields.

The stimulus meets these assumptions in four ways:
- It holds reset over the first edges.
- It applies bus reset only between transactions.
- It drives every request field at the falling edge, one request per strobe.
- It tracks the expected register contents step by step, so that each lock hits the success or failure branch it is meant to exercise.

// File: rtl/irm_lock_regs.sv
module irm_lock_regs #(
  parameter int          ADDR_W     = 8,
  parameter int          EXT_W      = 4,
  parameter logic [3:0]  CAS_CODE   = 4'd2,
  parameter logic [31:0] BM_DEFAULT = 32'h0000_003F,
  parameter logic [12:0] BW_DEFAULT = 13'd4915,
  parameter logic [31:0] HI_DEFAULT = 32'hFFFF_FFFE,
  parameter logic [31:0] LO_DEFAULT = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [EXT_W-1:0]  req_ext,
  input  logic [63:0]       req_arg,
  input  logic [63:0]       req_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [63:0]       rsp_value
);
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_L32 = 2'd2, K_L64 = 2'd3;
  localparam logic [1:0] C_OK = 2'd0, C_TYPE = 2'd1, C_ADDR = 2'd2;
  localparam logic [EXT_W-1:0] CAS = EXT_W'(CAS_CODE);

  logic [31:0] bm_q, hi_q, lo_q;
  logic [12:0] bw_q;
  logic [31:0] bm_n, hi_n, lo_n;
  logic [12:0] bw_n;
  logic [1:0]  code_n;
  logic [63:0] val_n;

  logic        aligned, mapped;
  logic [1:0]  idx;
  logic [31:0] arg32, dat32, cur_word;
  assign aligned = req_addr[1:0] == 2'b00;
  assign mapped  = req_addr[ADDR_W-1:4] == '0;
  assign idx     = req_addr[3:2];
  assign arg32   = req_arg[31:0];
  assign dat32   = req_data[31:0];

  always_comb begin
    case (idx)
      2'd0:    cur_word = bm_q;
      2'd1:    cur_word = {19'd0, bw_q};
      2'd2:    cur_word = hi_q;
      default: cur_word = lo_q;
    endcase
  end

  // channel 32-bit: the upper word never lets channel 31 be released
  logic [31:0] ch_dat, ch_aff;
  logic        ch_hit;
  assign ch_dat = (idx == 2'd2) ? (dat32 & 32'hFFFF_FFFE) : dat32;
  assign ch_aff = arg32 ^ ch_dat;
  assign ch_hit = (arg32 & ch_aff) == (cur_word & ch_aff);

  // channel 64-bit on {upper, lower}
  logic [63:0] w_old, w_dat, w_aff;
  logic        w_hit;
  assign w_old = {hi_q, lo_q};
  assign w_dat = req_data & ~64'h0000_0001_0000_0000;
  assign w_aff = req_arg ^ w_dat;
  assign w_hit = (req_arg & w_aff) == (w_old & w_aff);

  // bandwidth delta
  logic [12:0] bw_arg, bw_dat, bw_amt;
  logic [13:0] bw_sum;
  logic        bw_alloc;
  assign bw_arg   = arg32[12:0];
  assign bw_dat   = dat32[12:0];
  assign bw_alloc = bw_arg >= bw_dat;
  assign bw_amt   = bw_alloc ? (bw_arg - bw_dat) : (bw_dat - bw_arg);
  assign bw_sum   = {1'b0, bw_q} + {1'b0, bw_amt};

  always_comb begin
    bm_n = bm_q; bw_n = bw_q; hi_n = hi_q; lo_n = lo_q;
    code_n = C_OK;
    val_n  = '0;
    if (!aligned) begin
      code_n = C_TYPE;
    end else if (!mapped) begin
      code_n = C_ADDR;
    end else begin
      case (req_kind)
        K_RD: val_n = {32'd0, cur_word};
        K_WR: code_n = C_TYPE;
        default: begin
          if (req_ext != CAS || (req_kind == K_L64 && idx != 2'd2)) begin
            code_n = C_TYPE;
          end else if (req_kind == K_L64) begin
            val_n = w_hit ? req_arg : w_old;
            if (w_hit) {hi_n, lo_n} = w_old ^ w_aff;
          end else begin
            case (idx)
              2'd0: begin
                val_n = {32'd0, bm_q};
                if (bm_q == arg32) bm_n = dat32;
              end
              2'd1: begin
                val_n = {51'd0, bw_q};
                if (arg32 <= 32'h0000_1FFF) begin
                  if (bw_alloc && bw_q >= bw_amt) begin
                    bw_n  = bw_q - bw_amt;
                    val_n = {32'd0, arg32};
                  end else if (!bw_alloc && bw_sum < 14'h2000) begin
                    bw_n  = bw_sum[12:0];
                    val_n = {32'd0, arg32};
                  end
                end
              end
              default: begin
                val_n = {32'd0, ch_hit ? arg32 : cur_word};
                if (ch_hit) begin
                  if (idx == 2'd2) hi_n = hi_q ^ ch_aff;
                  else             lo_n = lo_q ^ ch_aff;
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bm_q <= BM_DEFAULT; bw_q <= BW_DEFAULT; hi_q <= HI_DEFAULT; lo_q <= LO_DEFAULT;
      rsp_valid <= 1'b0; rsp_code <= C_OK; rsp_value <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_code  <= code_n;
        rsp_value <= val_n;
      end
      if (bus_reset) begin
        bm_q <= BM_DEFAULT; bw_q <= BW_DEFAULT; hi_q <= HI_DEFAULT; lo_q <= LO_DEFAULT;
      end else if (req_valid) begin
        bm_q <= bm_n; bw_q <= bw_n; hi_q <= hi_n; lo_q <= lo_n;
      end
    end
  end

  p_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (bm_q == BM_DEFAULT && bw_q == BW_DEFAULT && hi_q == HI_DEFAULT && lo_q == LO_DEFAULT));

  p_bm_old_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == K_L32 && req_addr == '0 && req_ext == CAS)
    |=> rsp_value[31:0] == $past(bm_q));

  p_ch31_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q[0] == 1'b0);

  p_write_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == K_WR && !bus_reset)
    |=> ($stable(bm_q) && $stable(bw_q) && $stable(hi_q) && $stable(lo_q)));

  p_unaligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b00) |=> rsp_code == C_TYPE);

  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

// File: tb/irm_lock_regs_tb.sv
module irm_lock_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [7:0] req_addr = 8'd0;
  logic [3:0] req_ext = 4'd0;
  logic [63:0] req_arg = '0, req_data = '0;
  logic rsp_valid;
  logic [1:0] rsp_code;
  logic [63:0] rsp_value;

  always #5 clk = ~clk;

  irm_lock_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_ext(req_ext),
    .req_arg(req_arg), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_value(rsp_value));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [1:0]  q_code[$];
  logic [63:0] q_val[$];
  string       q_tag[$];

  localparam logic [1:0] RD = 0, WR = 1, L32 = 2, L64 = 3;
  localparam logic [1:0] OK = 0, TE = 1, AE = 2;
  localparam logic [3:0] CAS = 4'd2;

  task automatic issue(input logic [1:0] k, input logic [7:0] a, input logic [3:0] e,
                       input logic [63:0] arg, input logic [63:0] dat,
                       input logic [1:0] ec, input logic [63:0] ev, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_ext = e; req_arg = arg; req_data = dat;
    q_code.push_back(ec); q_val.push_back(ev); q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [63:0] ev, input string tag);
    issue(RD, a, 4'd0, '0, '0, OK, ev, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q_code.size() == 0) begin
        fails++;
        $display("FAIL R12 unexpected response code=%0d value=%h expected none", rsp_code, rsp_value);
      end else begin
        automatic logic [1:0] ec = q_code.pop_front();
        automatic logic [63:0] ev = q_val.pop_front();
        automatic string t = q_tag.pop_front();
        if (rsp_code !== ec || rsp_value !== ev) begin
          fails++;
          $display("FAIL %s: got code=%0d value=%h expected code=%0d value=%h", t, rsp_code, rsp_value, ec, ev);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired: got hung run expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++; $display("FAIL R12 reset: got rsp_valid=%b expected 0", rsp_valid);
    end
    rst_n = 1'b1;
    // R1 defaults
    rd(8'h00, 64'h3F, "R1 bm default");
    rd(8'h04, 64'h1333, "R1 bw default");
    rd(8'h08, 64'hFFFF_FFFE, "R1 hi default");
    rd(8'h0C, 64'hFFFF_FFFF, "R1 lo default");
    // R2 bus manager compare-swap
    issue(L32, 8'h00, CAS, 64'h10, 64'h05, OK, 64'h3F, "R2 bm mismatch");
    rd(8'h00, 64'h3F, "R2 bm unchanged");
    issue(L32, 8'h00, CAS, 64'h3F, 64'h05, OK, 64'h3F, "R2 bm match");
    rd(8'h00, 64'h05, "R2 bm stored");
    // R3 out-of-range arg
    issue(L32, 8'h04, CAS, 64'h2000, 64'h0, OK, 64'h1333, "R3 arg over range");
    rd(8'h04, 64'h1333, "R3 bw unchanged");
    // R4 allocate
    issue(L32, 8'h04, CAS, 64'h1333, 64'h1233, OK, 64'h1333, "R4 alloc ok");
    rd(8'h04, 64'h1233, "R4 bw reduced");
    issue(L32, 8'h04, CAS, 64'h1FFF, 64'h0, OK, 64'h1233, "R4 alloc too much");
    rd(8'h04, 64'h1233, "R4 bw unchanged");
    // R5 free
    issue(L32, 8'h04, CAS, 64'h1233, 64'h1333, OK, 64'h1233, "R5 free ok");
    issue(L32, 8'h04, CAS, 64'h0, 64'h1000, OK, 64'h1333, "R5 free overflow");
    issue(L32, 8'h04, CAS, 64'h0, 64'h0CCC, OK, 64'h0, "R5 free to 0x1FFF");
    rd(8'h04, 64'h1FFF, "R5 bw at top");
    issue(L32, 8'h04, CAS, 64'h1FFF, 64'hE000_1FFF, OK, 64'h1FFF, "R4 masked data zero amount");
    rd(8'h04, 64'h1FFF, "R4 bw after masked");
    // R6 channel lower
    issue(L32, 8'h0C, CAS, 64'hFFFF_FFFF, 64'hFFFF_FFFE, OK, 64'hFFFF_FFFF, "R6 alloc ch");
    issue(L32, 8'h0C, CAS, 64'hFFFF_FFFF, 64'hFFFF_FFFE, OK, 64'hFFFF_FFFE, "R6 alloc taken");
    issue(L32, 8'h0C, CAS, 64'hFFFF_FFFE, 64'hFFFF_FFFF, OK, 64'hFFFF_FFFE, "R6 free ch");
    rd(8'h0C, 64'hFFFF_FFFF, "R6 lo restored");
    // R7 channel 31
    issue(L32, 8'h08, CAS, 64'hFFFF_FFFE, 64'hFFFF_FFFF, OK, 64'hFFFF_FFFE, "R7 release ch31");
    rd(8'h08, 64'hFFFF_FFFE, "R7 ch31 kept");
    issue(L32, 8'h08, CAS, 64'hFFFF_FFFE, 64'hFFFF_FFFC, OK, 64'hFFFF_FFFE, "R6 hi alloc bit1");
    rd(8'h08, 64'hFFFF_FFFC, "R6 hi after alloc");
    // R8 64-bit
    issue(L64, 8'h08, CAS, 64'hFFFF_FFFC_FFFF_FFFF, 64'hFFFF_FFFD_7FFF_FFFF, OK,
          64'hFFFF_FFFC_FFFF_FFFF, "R8 lock64 ok");
    rd(8'h0C, 64'h7FFF_FFFF, "R8 lo updated");
    rd(8'h08, 64'hFFFF_FFFC, "R7 hi after lock64");
    issue(L64, 8'h08, CAS, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, OK,
          64'hFFFF_FFFC_7FFF_FFFF, "R8 lock64 mismatch");
    // R10 / R11
    issue(L64, 8'h04, CAS, '0, '0, TE, '0, "R10 lock64 at bw");
    issue(L64, 8'h0C, CAS, '0, '0, TE, '0, "R10 lock64 at lo");
    issue(L64, 8'h10, CAS, '0, '0, AE, '0, "R11 lock64 unmapped");
    // R9 writes
    issue(WR, 8'h00, 4'd0, '0, 64'h22, TE, '0, "R9 write bm");
    rd(8'h00, 64'h05, "R9 bm unchanged");
    issue(WR, 8'h0C, 4'd0, '0, 64'h0, TE, '0, "R9 write lo");
    rd(8'h0C, 64'h7FFF_FFFF, "R9 lo unchanged");
    issue(RD, 8'h05, 4'd0, '0, '0, TE, '0, "R10 unaligned read");
    issue(L32, 8'h00, 4'd1, 64'h05, 64'h09, TE, '0, "R10 non-cas lock");
    rd(8'h00, 64'h05, "R10 bm unchanged");
    issue(RD, 8'h10, 4'd0, '0, '0, AE, '0, "R11 read unmapped");
    issue(WR, 8'h40, 4'd0, '0, '0, AE, '0, "R11 write unmapped");
    issue(L32, 8'h20, 4'd1, '0, '0, AE, '0, "R11 lock unmapped");
    // R1 bus reset
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
    rd(8'h00, 64'h3F, "R1 bm after bus reset");
    rd(8'h04, 64'h1333, "R1 bw after bus reset");
    rd(8'h08, 64'hFFFF_FFFE, "R1 hi after bus reset");
    rd(8'h0C, 64'hFFFF_FFFF, "R1 lo after bus reset");
    repeat (3) @(negedge clk);
    checks++;
    if (q_code.size() != 0) begin
      fails++; $display("FAIL R12 missing responses: got %0d pending expected 0", q_code.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule